// File: doc/BRIEF.md
# Single-Line Machine Interrupt Controller

This block merges three machine-level interrupt causes into the one interrupt input of a small processor core. The three causes are software, timer and external. It holds a free-running cycle timer twice the bus width wide, a compare value of the same width, a software-interrupt word and a mask for a set of external request lines. A word-wide synchronous register port gives software access to all of these. Enables can only be changed by setting or clearing individual bits, so two handlers cannot undo each other's changes.

Software can move the wide timer and compare values atomically, although the bus carries only half of each per access. Reading the low timer word freezes the upper timer word in a hidden snapshot, and the snapshot is what the next read of the upper word returns. For the compare value, software first parks the upper word in a staging latch. A later write of the low compare word commits both halves in the same clock.

The output is a registered level. It stays high while any enabled cause is pending. Software clears it by removing the cause or by disabling it.

Top module: `irq_line_ctrl`

## Requirements
- R1: A write to byte offset 0x00 sets every enable bit written as 1, and a write to 0x04 clears every enable bit written as 1. Bits written as 0 are left alone. A read of 0x00 returns the enable mask. Only bit 3 (software), bit 7 (timer) and bit 11 (external) exist, and all other bits read 0.
- R2: A read of 0x04 returns the pending mask, with the same three bit positions as R1.
- R3: The software word at 0x20 is read/write. The software pending bit (bit 3) is high while that word is nonzero.
- R4: The timer is 0 after reset and increments by 1 on every clock. A read of 0x10 returns its low word, sampled in the cycle of the read strobe.
- R5: A read of 0x10 also copies the timer's upper word into a snapshot. A read of 0x14 returns only that snapshot, never the live upper word.
- R6: A write to 0x1C stores into the compare staging latch only, and a read of 0x1C returns the latch. A write to 0x18 loads the low compare word and, in the same clock, copies the latch into the upper compare word. A read of 0x18 returns the low compare word.
- R7: The timer pending bit (bit 7) is high whenever the full timer is greater than or equal to the full compare value, compared as unsigned numbers.
- R8: The external enable mask at 0x08 is read/write. A read of 0x0C returns the external request lines after a two-flop synchronizer. The external pending bit (bit 11) is high while the bitwise AND of the mask and the synchronized lines is nonzero.
- R9: `irq_o` is a register that follows, one clock later, the OR of (enable mask AND pending mask).
- R10: Reset clears the enables, the external mask, the software word, both compare words and the staging latch. A zero compare means the timer pending bit is high straight after reset.
- R11: Reads of unmapped offsets (0x24 and above, or any address with bits 1:0 nonzero) return 0. Writes to such offsets, and to the read-only offsets 0x04 (data part), 0x0C, 0x10 and 0x14, change no state.
- R12: Read data is registered. It appears in the cycle after the read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ext_irq_i | input | NUM_EXT | Asynchronous external request lines |
| irq_o | output | 1 | Combined level interrupt to the core |

## Verification
The bench builds the block with DATA_W = 16 and NUM_EXT = 16, so the timer is 32 bits wide and its upper word first changes after 65536 clocks. That puts a real carry into the upper half within a short run. The bench can then show that the snapshot at 0x14 stays stale until the low word is read, and it can place a compare value above 2^16 that has to be matched across both halves. The compare boundary is exercised cycle by cycle, one clock below and exactly at the compare value. The external path is probed edge by edge to confirm the two synchronizer stages plus one output register.

// File: rtl/irq_line_pkg.sv
package irq_line_pkg;
  localparam int SRC_W  = 12;
  localparam int SW_BIT = 3;
  localparam int TM_BIT = 7;
  localparam int EX_BIT = 11;
  localparam logic [SRC_W-1:0] IMPL_MASK = 12'h888;

  // word indices (byte offset / 4)
  localparam int OFS_EN    = 0;
  localparam int OFS_PEND  = 1;
  localparam int OFS_XEN   = 2;
  localparam int OFS_XSTAT = 3;
  localparam int OFS_TLO   = 4;
  localparam int OFS_THI   = 5;
  localparam int OFS_CLO   = 6;
  localparam int OFS_CLAT  = 7;
  localparam int OFS_SOFT  = 8;

  function automatic logic [SRC_W-1:0] pend_word(input logic sw, input logic tm, input logic ex);
    logic [SRC_W-1:0] w;
    w = '0;
    w[SW_BIT] = sw;
    w[TM_BIT] = tm;
    w[EX_BIT] = ex;
    return w;
  endfunction

  function automatic logic [SRC_W-1:0] next_enables(input logic [SRC_W-1:0] cur,
                                                    input logic [SRC_W-1:0] set_bits,
                                                    input logic [SRC_W-1:0] clr_bits);
    return (cur | (set_bits & IMPL_MASK)) & ~clr_bits;
  endfunction
endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q_o    <= '0;
    end else begin
      stage1 <= d_i;
      q_o    <= stage1;
    end
  end
endmodule

// File: rtl/irq_timer_core.sv
module irq_timer_core #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snap_i,
  output logic [2*HALF_W-1:0] count_o,
  output logic [HALF_W-1:0] hi_snap_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o   <= '0;
      hi_snap_o <= '0;
    end else begin
      count_o <= count_o + 1'b1;
      if (snap_i) hi_snap_o <= count_o[2*HALF_W-1:HALF_W];
    end
  end
endmodule

// File: rtl/irq_cmp_regs.sv
module irq_cmp_regs #(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_lat_i,
  input  logic                wr_lo_i,
  input  logic [HALF_W-1:0]   wdata_i,
  input  logic [2*HALF_W-1:0] timer_i,
  output logic [2*HALF_W-1:0] cmp_o,
  output logic [HALF_W-1:0]   lat_o,
  output logic                due_o
);
  function automatic logic reached(input logic [2*HALF_W-1:0] t, input logic [2*HALF_W-1:0] c);
    return t >= c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_o <= '0;
      lat_o <= '0;
    end else begin
      if (wr_lat_i) lat_o <= wdata_i;
      if (wr_lo_i)  cmp_o <= {lat_o, wdata_i};
    end
  end

  assign due_o = reached(timer_i, cmp_o);
endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl
  import irq_line_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_EXT = 32,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_EXT-1:0] ext_irq_i,
  output logic               irq_o
);
  localparam int TW     = 2 * DATA_W;
  localparam int WSEL_W = ADDR_W - 2;
  localparam logic [WSEL_W-1:0] S_EN    = WSEL_W'(OFS_EN);
  localparam logic [WSEL_W-1:0] S_PEND  = WSEL_W'(OFS_PEND);
  localparam logic [WSEL_W-1:0] S_XEN   = WSEL_W'(OFS_XEN);
  localparam logic [WSEL_W-1:0] S_XSTAT = WSEL_W'(OFS_XSTAT);
  localparam logic [WSEL_W-1:0] S_TLO   = WSEL_W'(OFS_TLO);
  localparam logic [WSEL_W-1:0] S_THI   = WSEL_W'(OFS_THI);
  localparam logic [WSEL_W-1:0] S_CLO   = WSEL_W'(OFS_CLO);
  localparam logic [WSEL_W-1:0] S_CLAT  = WSEL_W'(OFS_CLAT);
  localparam logic [WSEL_W-1:0] S_SOFT  = WSEL_W'(OFS_SOFT);

  logic [WSEL_W-1:0] wsel;
  logic              aligned;
  logic              wr_en_set, wr_en_clr, wr_xen, wr_soft, wr_clo, wr_clat, rd_tlo;

  logic [SRC_W-1:0]   en_vec;
  logic [SRC_W-1:0]   pend_vec;
  logic [TW-1:0]      timer_q;
  logic [TW-1:0]      cmp_q;
  logic [DATA_W-1:0]  cmp_lat;
  logic [DATA_W-1:0]  hi_snap;
  logic [DATA_W-1:0]  soft_q;
  logic [NUM_EXT-1:0] ext_en_q;
  logic [NUM_EXT-1:0] ext_s;
  logic               tm_due;
  logic               ext_hit;
  logic [DATA_W-1:0]  rd_val;

  assign wsel      = bus_addr[ADDR_W-1:2];
  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign wr_en_set = bus_wr && aligned && (wsel == S_EN);
  assign wr_en_clr = bus_wr && aligned && (wsel == S_PEND);
  assign wr_xen    = bus_wr && aligned && (wsel == S_XEN);
  assign wr_soft   = bus_wr && aligned && (wsel == S_SOFT);
  assign wr_clo    = bus_wr && aligned && (wsel == S_CLO);
  assign wr_clat   = bus_wr && aligned && (wsel == S_CLAT);
  assign rd_tlo    = bus_rd && aligned && (wsel == S_TLO);

  irq_sync2 #(.W(NUM_EXT)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ext_irq_i),
    .q_o   (ext_s)
  );

  irq_timer_core #(.HALF_W(DATA_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .snap_i    (rd_tlo),
    .count_o   (timer_q),
    .hi_snap_o (hi_snap)
  );

  irq_cmp_regs #(.HALF_W(DATA_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lat_i (wr_clat),
    .wr_lo_i  (wr_clo),
    .wdata_i  (bus_wdata),
    .timer_i  (timer_q),
    .cmp_o    (cmp_q),
    .lat_o    (cmp_lat),
    .due_o    (tm_due)
  );

  assign ext_hit  = |(ext_en_q & ext_s);
  assign pend_vec = pend_word(|soft_q, tm_due, ext_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_vec   <= '0;
      ext_en_q <= '0;
      soft_q   <= '0;
      irq_o    <= 1'b0;
    end else begin
      en_vec <= next_enables(en_vec,
                             wr_en_set ? bus_wdata[SRC_W-1:0] : '0,
                             wr_en_clr ? bus_wdata[SRC_W-1:0] : '0);
      if (wr_xen)  ext_en_q <= bus_wdata[NUM_EXT-1:0];
      if (wr_soft) soft_q   <= bus_wdata;
      irq_o <= |(en_vec & pend_vec);
    end
  end

  always_comb begin
    rd_val = '0;
    if (aligned) begin
      case (wsel)
        S_EN:    rd_val = DATA_W'(en_vec);
        S_PEND:  rd_val = DATA_W'(pend_vec);
        S_XEN:   rd_val = DATA_W'(ext_en_q);
        S_XSTAT: rd_val = DATA_W'(ext_s);
        S_TLO:   rd_val = timer_q[DATA_W-1:0];
        S_THI:   rd_val = hi_snap;
        S_CLO:   rd_val = cmp_q[DATA_W-1:0];
        S_CLAT:  rd_val = cmp_lat;
        S_SOFT:  rd_val = soft_q;
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/irq_line_ctrl_chk.sv
module irq_line_ctrl_chk
  import irq_line_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                irq_o,
  input logic [SRC_W-1:0]    en_vec,
  input logic [SRC_W-1:0]    pend_vec,
  input logic [2*DATA_W-1:0] timer_q,
  input logic [2*DATA_W-1:0] cmp_q,
  input logic [DATA_W-1:0]   cmp_lat,
  input logic [DATA_W-1:0]   hi_snap
);
  localparam int TW     = 2 * DATA_W;
  localparam int WSEL_W = ADDR_W - 2;

  logic [WSEL_W-1:0] sel;
  logic              al;
  logic              any_active;
  assign sel        = bus_addr[ADDR_W-1:2];
  assign al         = (bus_addr[1:0] == 2'b00);
  assign any_active = |(en_vec & pend_vec);

  assert_en_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && al && sel == WSEL_W'(OFS_EN) && bus_wdata[SW_BIT]) |=> en_vec[SW_BIT]);

  assert_en_clr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && al && sel == WSEL_W'(OFS_PEND) && bus_wdata[TM_BIT]) |=> !en_vec[TM_BIT]);

  assert_soft_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && al && sel == WSEL_W'(OFS_SOFT) && (|bus_wdata)) |=> pend_vec[SW_BIT]);

  assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> timer_q == $past(timer_q) + 1'b1);

  assert_hi_snapshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && al && sel == WSEL_W'(OFS_TLO)) |=> hi_snap == $past(timer_q[TW-1:DATA_W]));

  assert_cmp_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && al && sel == WSEL_W'(OFS_CLO)) |=> cmp_q == {$past(cmp_lat), $past(bus_wdata)});

  assert_irq_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any_active |=> irq_o);

  assert_irq_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_active |=> !irq_o);

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (!al || sel > WSEL_W'(OFS_SOFT))) |=> bus_rdata == '0);
endmodule

bind irq_line_ctrl irq_line_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .en_vec    (en_vec),
  .pend_vec  (pend_vec),
  .timer_q   (timer_q),
  .cmp_q     (cmp_q),
  .cmp_lat   (cmp_lat),
  .hi_snap   (hi_snap)
);

// File: tb/irq_line_ctrl_test.sv
`timescale 1ns/1ps
module irq_line_ctrl_test;
  localparam int DW = 16;
  localparam int NX = 16;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NX-1:0] ext_irq_i = '0;
  logic          irq_o;

  int checks = 0;
  int fails = 0;
  logic [31:0] tb_time;
  logic        rd_q;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic [DW-1:0] last_exp;
  logic [15:0]   snap_exp;
  logic [31:0]   v;

  always #2.5 clk = ~clk;

  irq_line_ctrl #(.DATA_W(DW), .NUM_EXT(NX), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_irq_i(ext_irq_i), .irq_o(irq_o)
  );

  // reference cycle count, from the requirement: 0 in reset, +1 per clock
  always @(posedge clk) begin
    if (!rst_n) tb_time <= 0;
    else        tb_time <= tb_time + 1;
    rd_q <= bus_rd;
  end

  // monitor: compares registered read data one clock after each strobe
  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: read data actual %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    last_exp = e;
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", t, act, e);
    end
  endtask

  initial begin
    #(150000 * 5.0);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk(irq_o, 1'b0, "R10 irq after reset");
    rd(6'h00, 16'h0000, "R10 enables reset");
    rd(6'h04, 16'h0080, "R10 R7 R2 timer pending with zero compare");
    rd(6'h08, 16'h0000, "R10 ext mask reset");
    rd(6'h20, 16'h0000, "R10 soft reset");
    rd(6'h1C, 16'h0000, "R10 latch reset");
    rd(6'h18, 16'h0000, "R10 compare reset");

    // R1 set / clear
    wr(6'h00, 16'hFFFF);
    rd(6'h00, 16'h0888, "R1 set only implemented bits");
    wr(6'h04, 16'h0080);
    rd(6'h00, 16'h0808, "R1 clear timer enable");
    wr(6'h00, 16'h0000);
    rd(6'h00, 16'h0808, "R1 zero bits unchanged");
    @(negedge clk);
    chk(irq_o, 1'b0, "R9 timer pending but disabled");

    // R3 software source
    wr(6'h20, 16'h0005);
    chk(irq_o, 1'b0, "R9 output lags by one clock");
    @(negedge clk);
    chk(irq_o, 1'b1, "R3 R9 software interrupt raised");
    rd(6'h20, 16'h0005, "R3 soft readback");
    rd(6'h04, 16'h0088, "R2 R3 pending soft and timer");
    wr(6'h20, 16'h0000);
    rd(6'h04, 16'h0080, "R3 soft pending cleared");
    chk(irq_o, 1'b0, "R3 R9 irq drops");

    // R6 R7 compare path
    wr(6'h1C, 16'h0001);
    rd(6'h1C, 16'h0001, "R6 latch readback");
    rd(6'h04, 16'h0080, "R6 latch alone has no effect");
    wr(6'h18, 16'h0000);
    rd(6'h18, 16'h0000, "R6 low compare readback");
    rd(6'h04, 16'h0000, "R6 R7 upper half committed");
    wr(6'h00, 16'h0080);
    rd(6'h00, 16'h0888, "R1 timer enable set");
    chk(irq_o, 1'b0, "R7 timer below compare");

    // R8 external path
    wr(6'h08, 16'h0005);
    rd(6'h08, 16'h0005, "R8 ext mask readback");
    ext_irq_i = 16'h0012;
    repeat (2) @(negedge clk);
    rd(6'h0C, 16'h0012, "R8 synchronized status");
    rd(6'h04, 16'h0000, "R8 masked lines give no pending");
    ext_irq_i = 16'h0014;
    @(negedge clk);
    chk(irq_o, 1'b0, "R8 sync stage 1");
    @(negedge clk);
    chk(irq_o, 1'b0, "R8 sync stage 2");
    @(negedge clk);
    chk(irq_o, 1'b1, "R8 R9 irq after sync plus register");
    rd(6'h04, 16'h0800, "R8 ext pending");
    rd(6'h0C, 16'h0014, "R8 status follows lines");
    ext_irq_i = '0;
    repeat (3) @(negedge clk);
    rd(6'h04, 16'h0000, "R8 ext pending gone");
    chk(irq_o, 1'b0, "R8 irq gone");

    // R11 ignored writes and unmapped reads
    wr(6'h0C, 16'hFFFF);
    wr(6'h14, 16'hFFFF);
    wr(6'h24, 16'hFFFF);
    wr(6'h01, 16'hFFFF);
    rd(6'h0C, 16'h0000, "R11 status not writable");
    rd(6'h14, 16'h0000, "R11 snapshot not writable");
    rd(6'h24, 16'h0000, "R11 unmapped read");
    rd(6'h3C, 16'h0000, "R11 top unmapped read");
    rd(6'h01, 16'h0000, "R11 misaligned read");
    rd(6'h00, 16'h0888, "R11 misaligned write ignored");
    wr(6'h10, 16'hFFFF);
    rd(6'h10, tb_time[15:0], "R4 R11 timer not writable");

    // R4 timer
    repeat (37) @(negedge clk);
    rd(6'h10, tb_time[15:0], "R4 timer low word");
    // R12 hold
    repeat (4) @(negedge clk);
    checks++;
    if (bus_rdata !== last_exp) begin
      fails++;
      $display("FAIL R12 read data hold: actual %h expected %h", bus_rdata, last_exp);
    end

    // R5 R7 across the upper-half carry
    while (tb_time < 32'd65600) @(negedge clk);
    chk(irq_o, 1'b1, "R7 timer reached wide compare");
    rd(6'h04, 16'h0080, "R7 timer pending");
    rd(6'h14, 16'h0000, "R5 snapshot stale until low read");
    snap_exp = tb_time[31:16];
    rd(6'h10, tb_time[15:0], "R4 timer low after carry");
    rd(6'h14, snap_exp, "R5 snapshot of upper word");

    // R7 exact boundary
    v = tb_time + 32'd100;
    wr(6'h1C, v[31:16]);
    wr(6'h18, v[15:0]);
    rd(6'h04, 16'h0000, "R7 above timer");
    while (tb_time != v - 1) @(negedge clk);
    rd(6'h04, 16'h0000, "R7 one below compare");
    rd(6'h04, 16'h0080, "R7 equal to compare");
    wr(6'h1C, 16'hFFFF);
    wr(6'h18, 16'h0000);
    rd(6'h04, 16'h0000, "R7 unsigned large compare");
    @(negedge clk);
    chk(irq_o, 1'b0, "R7 R9 irq cleared by compare");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule